// File: doc/BRIEF.md
# Write-Only Three-Byte I2C Command Receiver

This block is a receive-only target on a two-wire serial bus. It runs on a fast system clock and oversamples the bus clock and data lines through synchronizers. It finds bus start and stop conditions and compares the incoming 7-bit target address with two values: a configured address input and a fixed broadcast address. When either address matches and the transfer is a write, the block acknowledges by pulling the data line low.

The block then takes exactly three data bytes and acknowledges each one. When the acknowledge clock of the third byte ends, it presents the assembled 24-bit command word together with a strobe that lasts one cycle. The word holds a 4-bit opcode, a 4-bit channel number and a 16-bit data value. The block never answers a read request. It refuses any byte after the third, and it drops a transfer that ends early without delivering anything.

Top module: `i2c_cmd_rx`

## Requirements
- R1: After synchronous reset, `sda_pull` and `word_valid` are both 0.
- R2: An address byte whose upper seven bits (first sent, MSB first) equal `own_addr` and whose eighth bit (0 = write) is 0 is acknowledged: `sda_pull` is 1 during the high phase of the ninth clock.
- R3: An address byte carrying the broadcast address (parameter `GLOBAL_ADDR`, default 7'h73) with the write bit is acknowledged in the same way.
- R4: An address that matches neither value gets no acknowledge, and none of the bytes that follow it is acknowledged or delivered.
- R5: A matched address with the eighth bit 1 (read) gets no acknowledge, and `sda_pull` stays 0 through that transfer.
- R6: After a matched write address, each of the first three data bytes is acknowledged on its ninth clock.
- R7: Any data byte after the third in the same transfer is not acknowledged, and the command word is delivered only once.
- R8: The delivered word places data byte 1 in bits 23:16 (opcode in 23:20, channel in 19:16), byte 2 in bits 15:8 and byte 3 in bits 7:0. Each byte is sampled on rising bus-clock edges, MSB first.
- R9: `word_valid` is high for exactly one system-clock cycle per delivered word.
- R10: A stop or a repeated start at any point abandons the current transfer and returns to address reception. A word with fewer than three complete bytes is never delivered.
- R11: `sda_pull` rises only after the bus-clock falling edge that ends the eighth bit, and falls after the falling edge that ends the ninth bit. It never changes while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| own_addr | input | 7 | Configured target address |
| sda_pull | output | 1 | 1 drives the data line low (open-drain enable) |
| word_o | output | 24 | Last delivered command word |
| word_valid | output | 1 | One-cycle strobe marking a new `word_o` |

## Verification
The assertions assume a well-formed bus in which the controller changes the data line only while the clock is low, except when it makes start and stop conditions. Under that assumption the acknowledge pull-down can never coincide with a start or stop. They also assume that each bus-clock phase lasts several system cycles, so that the two synchronizer flops do not skew the clock and data lines apart. The stimulus keeps to this: every bus-clock quarter period lasts ten system cycles, and data changes only at the middle of the low phase. Stops and repeated starts are issued only after the clock is low and the target has let go of the line.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    localparam int ADDR_W     = 7;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 3;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int BITCNT_W   = $clog2(BYTE_W + 2);
    localparam int BYTECNT_W  = $clog2(WORD_BYTES + 1);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ADDR,
        RX_DATA
    } rx_state_e;

    typedef struct packed {
        logic [3:0]  opcode;
        logic [3:0]  channel;
        logic [15:0] value;
    } cmd_word_t;

    function automatic logic addr_accept(input logic [BYTE_W-1:0] hdr,
                                         input logic [ADDR_W-1:0] mine,
                                         input logic [ADDR_W-1:0] bcast);
        logic [ADDR_W-1:0] a;
        a = hdr[BYTE_W-1:1];
        return ((a == mine) || (a == bcast)) && (hdr[0] == 1'b0);
    endfunction
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);
    logic [LINES-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmdrx_cond.sv
module cmdrx_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign bus_start =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign bus_stop  =  scl_s &  scl_d & ~sda_d &  sda_s;
endmodule

// File: rtl/cmdrx_engine.sv
module cmdrx_engine
    import i2c_cmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GLOBAL_ADDR = 7'h73
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              ack_drive,
    output cmd_word_t         word,
    output logic              word_stb
);
    localparam logic [BITCNT_W-1:0]  LAST_BIT = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0]  ACK_BIT  = BITCNT_W'(BYTE_W + 1);
    localparam logic [BYTECNT_W-1:0] NBYTES   = BYTECNT_W'(WORD_BYTES);
    localparam int                   ACC_W    = WORD_W - BYTE_W;

    rx_state_e             state;
    logic [BITCNT_W-1:0]   bit_cnt;
    logic [BYTECNT_W-1:0]  byte_cnt;
    logic [BYTE_W-1:0]     shreg;
    logic [ACC_W-1:0]      acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            shreg     <= '0;
            acc       <= '0;
            ack_drive <= 1'b0;
            word      <= '0;
            word_stb  <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (bus_start) begin
                state     <= RX_ADDR;
                bit_cnt   <= '0;
                byte_cnt  <= '0;
                ack_drive <= 1'b0;
            end else if (bus_stop) begin
                state     <= RX_IDLE;
                bit_cnt   <= '0;
                ack_drive <= 1'b0;
            end else if (state != RX_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < LAST_BIT) shreg <= {shreg[BYTE_W-2:0], sda_s};
                    if (bit_cnt < ACK_BIT)  bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall) begin
                    if (bit_cnt == LAST_BIT) begin
                        if (state == RX_ADDR) begin
                            ack_drive <= addr_accept(shreg, own_addr, GLOBAL_ADDR);
                        end else if (byte_cnt < NBYTES) begin
                            ack_drive <= 1'b1;
                            if (byte_cnt < NBYTES - 1'b1)
                                acc <= {acc[ACC_W-BYTE_W-1:0], shreg};
                        end
                    end else if (bit_cnt == ACK_BIT) begin
                        bit_cnt   <= '0;
                        ack_drive <= 1'b0;
                        if (state == RX_ADDR) begin
                            state <= ack_drive ? RX_DATA : RX_IDLE;
                        end else if (byte_cnt < NBYTES) begin
                            byte_cnt <= byte_cnt + 1'b1;
                            if (byte_cnt == NBYTES - 1'b1) begin
                                word     <= cmd_word_t'({acc, shreg});
                                word_stb <= 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_rx.sv
module i2c_cmd_rx
    import i2c_cmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GLOBAL_ADDR = 7'h73,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_pull,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, cond_start, cond_stop;
    cmd_word_t  word_q;

    cmdrx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    cmdrx_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (cond_start),
        .bus_stop  (cond_stop)
    );

    cmdrx_engine #(.GLOBAL_ADDR(GLOBAL_ADDR)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (cond_start),
        .bus_stop  (cond_stop),
        .own_addr  (own_addr),
        .ack_drive (sda_pull),
        .word      (word_q),
        .word_stb  (word_valid)
    );

    assign word_o = word_q;
endmodule

// File: rtl/i2c_cmd_rx_chk.sv
module i2c_cmd_rx_chk (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic bus_stop,
    input logic sda_pull,
    input logic word_valid
);
    // R9: strobe is a single cycle
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R11: pull-down begins only while the bus clock is low
    a_r11_rise_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_lvl);

    // R11: pull-down is steady through a bus-clock high phase
    a_r11_hold_high: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));

    // R6: delivery follows the acknowledge of the third byte
    a_r6_after_ack: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($past(sda_pull) && !sda_pull));

    // R10: a stop leaves the line released
    a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !sda_pull);
endmodule

bind i2c_cmd_rx i2c_cmd_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl    (scl_s),
    .bus_stop   (cond_stop),
    .sda_pull   (sda_pull),
    .word_valid (word_valid)
);

// File: tb/tb_i2c_cmd_rx.sv
module tb_i2c_cmd_rx;
    localparam logic [6:0] OWN = 7'h2C;
    localparam logic [6:0] GLB = 7'h73;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_pull, word_valid;
    logic [23:0] word_o;
    logic sda_line;

    int errors = 0;
    int checks = 0;
    int n_exp = 0;
    int n_got = 0;
    bit done = 0;
    bit prev_valid = 0;
    logic [23:0] exp_q[$];

    always #4 clk = ~clk;
    assign sda_line = sda_drv & ~sda_pull;

    i2c_cmd_rx #(.GLOBAL_ADDR(GLB)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .own_addr(OWN), .sda_pull(sda_pull), .word_o(word_o),
        .word_valid(word_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_drv = 1'b1; wt(Q);
        scl = 1'b1;     wt(Q);
        sda_drv = 1'b0; wt(Q);
        scl = 1'b0;     wt(Q);
    endtask

    task automatic do_stop();
        sda_drv = 1'b0; wt(Q);
        scl = 1'b1;     wt(Q);
        sda_drv = 1'b1; wt(2 * Q);
    endtask

    task automatic send_bit(input logic b, output logic seen);
        sda_drv = b; wt(Q);
        scl = 1'b1;  wt(Q);
        seen = sda_pull;
        wt(Q);
        scl = 1'b0;  wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input string req);
        logic any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            logic s;
            send_bit(v[i], s);
            any |= s;
        end
        chk(!any, req, any, 0);
    endtask

    task automatic ack_slot(input bit exp, input string req);
        logic got;
        sda_drv = 1'b1; wt(Q);
        scl = 1'b1;     wt(Q);
        got = sda_pull;
        chk(got == exp, req, got, exp);
        wt(Q);
        scl = 1'b0;     wt(Q);
        chk(!sda_pull, "R11 release", sda_pull, 0);
    endtask

    task automatic txn(input logic [6:0] a, input logic rw, input int nb,
                       input logic [31:0] d, input string tag);
        bit hit;
        hit = ((a == OWN) || (a == GLB)) && !rw;
        do_start();
        send_byte({a, rw}, "R11 no pull in address bits");
        ack_slot(hit, tag);
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b;
            b = (i < 4) ? d[31 - 8*i -: 8] : 8'hA5;
            send_byte(b, "R11 no pull in data bits");
            if (hit && i == 2) begin
                exp_q.push_back(d[31:8]);
                n_exp++;
            end
            ack_slot(hit && (i < 3), (i < 3) ? (hit ? "R6 data ack" : "R4/R5 no data ack") : "R7 extra byte refused");
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (word_valid) begin
                n_got++;
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected word", word_o, 0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk(word_o == e, "R8 word layout", word_o, e);
                end
                chk(!prev_valid, "R9 single-cycle strobe", prev_valid, 0);
            end
            prev_valid = word_valid;
        end
    end

    initial begin
        wt(5);
        chk(sda_pull == 1'b0, "R1 pull at reset", sda_pull, 0);
        chk(word_valid == 1'b0, "R1 valid at reset", word_valid, 0);
        @(negedge clk) rst = 1'b0;
        wt(4 * Q);

        txn(OWN, 1'b0, 3, 32'h3ABEEF00, "R2 own address ack");
        do_stop();
        txn(GLB, 1'b0, 5, 32'h51234567, "R3 broadcast ack");
        do_stop();
        txn(7'h11, 1'b0, 3, 32'h12345600, "R4 mismatch no ack");
        do_stop();
        txn(OWN, 1'b1, 3, 32'h99887700, "R5 read no ack");
        do_stop();
        txn(OWN, 1'b0, 2, 32'hDEAD0000, "R10 short transfer ack");
        do_stop();
        // abort mid-byte with repeated start
        txn(OWN, 1'b0, 1, 32'h77000000, "R10 partial ack");
        for (int i = 0; i < 4; i++) begin
            logic s;
            send_bit(i[0], s);
        end
        txn(OWN, 1'b0, 3, 32'hF0FF0000, "R10 restart ack");
        do_stop();
        txn(OWN, 1'b0, 3, 32'h00000100, "R8 all-zero edges");
        do_stop();
        wt(4 * Q);

        chk(exp_q.size() == 0, "R10 no missing words", exp_q.size(), 0);
        chk(n_got == n_exp, "R7 delivery count", n_got, n_exp);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule